// File: doc/BRIEF.md
# Special-Purpose Register Bank

This block is a bank of 16-bit special registers beside a small processor's general register file. A single instruction moves data in either direction. A 6-bit address selects the entry, and one direction bit chooses between a write from a general register (1) and a read into a general register (0). Some addresses are plain storage. Others are tied to processor state or to pins:

- four entries drive display outputs;
- one entry mirrors a switch input;
- one entry is a read-only copy of the program counter;
- two entries hold the exception return address and the interrupt flag word, which hardware loads on interrupt entry.

Reads are combinational from the current state, so the value is available in the same cycle the access is presented. Writes take effect at the next rising clock edge. The hardware side inputs use their own strobes and can fire in the same cycle as a software access.

Top module: `spec_reg_bank`

## Requirements
- R1: After reset, every readable entry and all four display outputs are zero.
- R2: A write to address j (0 to 3) sets display field `disp_bus[16*j+15:16*j]` at the next edge. The other display fields do not change.
- R3: While `acc_en=1` and `acc_wr=0`, `rd_data` shows the addressed entry in the same cycle. In any other cycle `rd_data` is zero.
- R4: Addresses 10 to 32 are independent read/write storage, each keeping the last value written.
- R5: Software writes to addresses 4, 5, 6, 9 and 33 to 63 change nothing, including the entry at the same low address bits. Reads of 4, 9 and 33 to 63 return zero.
- R6: A read of address 5 returns `switch_in` through a two-stage synchronizer. A change becomes visible after the second rising edge.
- R7: Address 6 reads the value loaded by `pc_upd_en`/`pc_upd_val` and is not changed by software.
- R8: When `trap_en` is high, address 7 is loaded with `trap_pc` and address 8 is loaded with `{trap_type, 7'b0, trap_code}`: type in bits 15:13, code in bits 5:0.
- R9: Software may write address 7 in full. A software write to address 8 keeps bits 15:13 and 5:0 of the data and clears bits 12:6.
- R10: When a hardware load and a software write target the same entry (6, 7 or 8) in the same cycle, the hardware value is stored.
- R11: An access with `acc_en=0`, or a read access, modifies no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | Direction: 1 write into bank, 0 read out |
| acc_addr | input | 6 | Entry address |
| wr_data | input | 16 | Data from the general register |
| rd_data | output | 16 | Read result, zero when not reading |
| pc_upd_en | input | 1 | Load the program-counter copy |
| pc_upd_val | input | 16 | Program counter value |
| trap_en | input | 1 | Interrupt entry: load return address and flag |
| trap_pc | input | 16 | Return address to save |
| trap_type | input | 3 | Interrupt type field |
| trap_code | input | 6 | Interrupt value field |
| switch_in | input | 16 | Asynchronous switch levels |
| disp_bus | output | 64 | Four 16-bit display values, entry 0 in the low bits |

## Verification
Two things can happen in the same cycle: a hardware load of the PC copy, return address or flag word, and a software write to that same entry. The bench raises `pc_upd_en` or `trap_en` in the same cycle as a write to 6, 7 or 8 with a contrasting value such as all ones. It then reads the entry back and expects the hardware value. For the flag word this means the packed type and code with the middle bits clear.

// File: rtl/spec_reg_bank.sv
module spec_reg_bank #(
  parameter int DW      = 16,
  parameter int AW      = 6,
  parameter int NDISP   = 4,
  parameter int KEEP_LO = 10,
  parameter int KEEP_HI = 32,
  parameter int TW      = 3,
  parameter int CW      = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_wr,
  input  logic [AW-1:0]       acc_addr,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_data,
  input  logic                pc_upd_en,
  input  logic [DW-1:0]       pc_upd_val,
  input  logic                trap_en,
  input  logic [DW-1:0]       trap_pc,
  input  logic [TW-1:0]       trap_type,
  input  logic [CW-1:0]       trap_code,
  input  logic [DW-1:0]       switch_in,
  output logic [NDISP*DW-1:0] disp_bus
);
  localparam int NKEEP = KEEP_HI - KEEP_LO + 1;
  localparam int RW    = DW - TW - CW;
  localparam logic [AW-1:0] A_SW   = AW'(5);
  localparam logic [AW-1:0] A_PC   = AW'(6);
  localparam logic [AW-1:0] A_EPC  = AW'(7);
  localparam logic [AW-1:0] A_FLAG = AW'(8);

  logic          sw_wr, rd_en;
  logic [DW-1:0] disp_q [NDISP];
  logic [DW-1:0] keep_q [NKEEP];
  logic [DW-1:0] sw_s1, sw_s2, pc_q, epc_q, flag_q, rd_mux;

  assign sw_wr = acc_en & acc_wr;
  assign rd_en = acc_en & ~acc_wr;

  for (genvar j = 0; j < NDISP; j++) begin : g_disp
    always_ff @(posedge clk)
      if (!rst_n) disp_q[j] <= '0;
      else if (sw_wr && acc_addr == AW'(j)) disp_q[j] <= wr_data;
    assign disp_bus[j*DW +: DW] = disp_q[j];
  end

  for (genvar k = 0; k < NKEEP; k++) begin : g_keep
    always_ff @(posedge clk)
      if (!rst_n) keep_q[k] <= '0;
      else if (sw_wr && acc_addr == AW'(KEEP_LO + k)) keep_q[k] <= wr_data;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      sw_s1 <= '0;
      sw_s2 <= '0;
    end else begin
      sw_s1 <= switch_in;
      sw_s2 <= sw_s1;
    end

  always_ff @(posedge clk)
    if (!rst_n) pc_q <= '0;
    else if (pc_upd_en) pc_q <= pc_upd_val;

  always_ff @(posedge clk)
    if (!rst_n) epc_q <= '0;
    else if (trap_en) epc_q <= trap_pc;
    else if (sw_wr && acc_addr == A_EPC) epc_q <= wr_data;

  always_ff @(posedge clk)
    if (!rst_n) flag_q <= '0;
    else if (trap_en) flag_q <= {trap_type, {RW{1'b0}}, trap_code};
    else if (sw_wr && acc_addr == A_FLAG)
      flag_q <= {wr_data[DW-1 -: TW], {RW{1'b0}}, wr_data[CW-1:0]};

  always_comb begin
    rd_mux = '0;
    for (int j = 0; j < NDISP; j++)
      if (acc_addr == AW'(j)) rd_mux = disp_q[j];
    for (int k = 0; k < NKEEP; k++)
      if (acc_addr == AW'(KEEP_LO + k)) rd_mux = keep_q[k];
    if (acc_addr == A_SW)   rd_mux = sw_s2;
    if (acc_addr == A_PC)   rd_mux = pc_q;
    if (acc_addr == A_EPC)  rd_mux = epc_q;
    if (acc_addr == A_FLAG) rd_mux = flag_q;
  end

  assign rd_data = rd_en ? rd_mux : '0;
endmodule

module spec_reg_bank_chk #(
  parameter int DW = 16, AW = 6, NDISP = 4, KEEP_HI = 32, TW = 3, CW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_en,
  input logic                acc_wr,
  input logic [AW-1:0]       acc_addr,
  input logic [DW-1:0]       rd_data,
  input logic                pc_upd_en,
  input logic                trap_en,
  input logic [DW-1:0]       trap_pc,
  input logic [TW-1:0]       trap_type,
  input logic [CW-1:0]       trap_code,
  input logic [NDISP*DW-1:0] disp_bus,
  input logic [DW-1:0]       pc_q,
  input logic [DW-1:0]       epc_q,
  input logic [DW-1:0]       flag_q
);
  localparam int RW = DW - TW - CW;

  a_r2_disp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr && acc_addr < AW'(NDISP)) |=> $stable(disp_bus));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |-> rd_data == '0);

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && (acc_addr == AW'(4) || acc_addr == AW'(9) || acc_addr > AW'(KEEP_HI)))
    |-> rd_data == '0);

  a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_upd_en |=> $stable(pc_q));

  a_r8_trap_epc: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> epc_q == $past(trap_pc));

  a_r10_flag_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> flag_q == {$past(trap_type), {RW{1'b0}}, $past(trap_code)});

  a_r9_flag_mid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[DW-TW-1:CW] == '0);
endmodule

bind spec_reg_bank spec_reg_bank_chk #(
  .DW(DW), .AW(AW), .NDISP(NDISP), .KEEP_HI(KEEP_HI), .TW(TW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .rd_data(rd_data), .pc_upd_en(pc_upd_en), .trap_en(trap_en), .trap_pc(trap_pc),
  .trap_type(trap_type), .trap_code(trap_code), .disp_bus(disp_bus),
  .pc_q(pc_q), .epc_q(epc_q), .flag_q(flag_q)
);

// File: tb/tb_spec_reg_bank.sv
module tb_spec_reg_bank;
  localparam int PER = 10;

  logic        clk = 0, rst_n = 0;
  logic        acc_en = 0, acc_wr = 0, pc_upd_en = 0, trap_en = 0;
  logic [5:0]  acc_addr = '0;
  logic [15:0] wr_data = '0, pc_upd_val = '0, trap_pc = '0, switch_in = '0;
  logic [2:0]  trap_type = '0;
  logic [5:0]  trap_code = '0;
  logic [15:0] rd_data;
  logic [63:0] disp_bus;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct { int sel; logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #(PER/2) clk = ~clk;

  spec_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .wr_data(wr_data), .rd_data(rd_data), .pc_upd_en(pc_upd_en), .pc_upd_val(pc_upd_val),
    .trap_en(trap_en), .trap_pc(trap_pc), .trap_type(trap_type), .trap_code(trap_code),
    .switch_in(switch_in), .disp_bus(disp_bus)
  );

  task automatic op(input bit en, input bit wr, input logic [5:0] a, input logic [15:0] d,
                    input bit pc_en = 0, input logic [15:0] pcv = '0, input bit tr_en = 0);
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_addr = a; wr_data = d;
    pc_upd_en = pc_en; pc_upd_val = pcv; trap_en = tr_en;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
    op(1, 0, a, '0);
    sb_q.push_back('{0, e, tag});
  endtask

  task automatic rd_off(input logic [5:0] a, input logic [15:0] e, input string tag);
    op(0, 0, a, '0);
    sb_q.push_back('{0, e, tag});
  endtask

  task automatic exp_disp(input int j, input logic [15:0] e, input string tag);
    sb_q.push_back('{j + 1, e, tag});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(PER/4);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = sb_q.pop_front();
        got = (it.sel == 0) ? rd_data : disp_bus[(it.sel-1)*16 +: 16];
        n_vec++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(PER*20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'd0, 16'h0, "R1 disp0 entry"); rd(6'd6, 16'h0, "R1 pc");
    rd(6'd7, 16'h0, "R1 epc"); rd(6'd8, 16'h0, "R1 flag");
    rd(6'd10, 16'h0, "R1 keep10"); rd(6'd32, 16'h0, "R1 keep32");
    for (int j = 0; j < 4; j++) exp_disp(j, 16'h0, "R1 display");
    // R2 display writes
    for (int j = 0; j < 4; j++) begin
      op(1, 1, 6'(j), 16'hA000 + 16'(j*16'h0111));
      rd(6'(j), 16'hA000 + 16'(j*16'h0111), "R3 display readback");
      for (int m = 0; m < 4; m++)
        exp_disp(m, (m <= j) ? 16'hA000 + 16'(m*16'h0111) : 16'h0, "R2 display field");
    end
    // R3 / R11 no-read and no-write
    rd_off(6'd1, 16'h0, "R3 idle rd_data zero");
    op(0, 1, 6'd2, 16'hFFFF);
    rd(6'd2, 16'hA222, "R11 disabled write");
    exp_disp(2, 16'hA222, "R11 display unchanged");
    // R4 storage
    op(1, 1, 6'd10, 16'h1010); op(1, 1, 6'd20, 16'h2020); op(1, 1, 6'd32, 16'h3232);
    rd(6'd10, 16'h1010, "R4 keep10"); rd(6'd20, 16'h2020, "R4 keep20");
    rd(6'd32, 16'h3232, "R4 keep32"); rd(6'd11, 16'h0, "R4 keep11 untouched");
    // R5 ignored writes and zero reads
    op(1, 1, 6'd4, 16'h4444); op(1, 1, 6'd9, 16'h9999);
    op(1, 1, 6'd33, 16'h3333); op(1, 1, 6'd42, 16'hBEEF);
    rd(6'd4, 16'h0, "R5 addr4"); rd(6'd9, 16'h0, "R5 addr9");
    rd(6'd33, 16'h0, "R5 addr33"); rd(6'd63, 16'h0, "R5 addr63");
    rd(6'd10, 16'h1010, "R5 alias of 42 untouched");
    // R6 switch sync
    switch_in = 16'h1234;
    rd(6'd5, 16'h0, "R6 after one edge");
    rd(6'd5, 16'h1234, "R6 after two edges");
    op(1, 1, 6'd5, 16'hFFFF);
    rd(6'd5, 16'h1234, "R5 switch write ignored");
    // R7 pc copy
    op(0, 0, 6'd0, '0, 1, 16'h0200);
    rd(6'd6, 16'h0200, "R7 pc load");
    op(1, 1, 6'd6, 16'hDEAD);
    rd(6'd6, 16'h0200, "R7 software write ignored");
    // R8 trap entry
    trap_pc = 16'h0456; trap_type = 3'd5; trap_code = 6'h2A;
    op(0, 0, 6'd0, '0, 0, '0, 1);
    rd(6'd7, 16'h0456, "R8 epc");
    rd(6'd8, 16'hA02A, "R8 flag packing");
    // R9 software writes
    op(1, 1, 6'd8, 16'hFFFF);
    rd(6'd8, 16'hE03F, "R9 flag mid bits clear");
    op(1, 1, 6'd7, 16'h1111);
    rd(6'd7, 16'h1111, "R9 epc write");
    // R10 hardware wins
    trap_pc = 16'h0777; trap_type = 3'd2; trap_code = 6'h01;
    op(1, 1, 6'd8, 16'hFFFF, 0, '0, 1);
    rd(6'd8, 16'h4001, "R10 flag conflict");
    rd(6'd7, 16'h0777, "R8 epc on second trap");
    op(1, 1, 6'd7, 16'h1234, 0, '0, 1);
    rd(6'd7, 16'h0777, "R10 epc conflict");
    op(1, 1, 6'd6, 16'hFFFF, 1, 16'h0ABC);
    rd(6'd6, 16'h0ABC, "R10 pc conflict");
    op(0, 0, 6'd0, '0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule